// File: doc/BRIEF.md
# Handshaked Register Field Bank

This block is a memory-mapped control and status slave. A single request/response bus carries 32-bit accesses to byte addresses aligned to 4. The bank decodes the address to one of four words and opens a handshake with every field packed into that word. Each field can answer at once or hold the access until it is ready. Plain register fields and status fields always answer in the same cycle. A field backed by an external queue answers only when its source holds data or its sink can take data.

Every field runs its own valid/ready exchange. The bank remembers which fields of the current access have already finished, and it never offers a finished field a second valid. The response goes out once the last field has finished. Only one request is outstanding at a time. An address outside the map finishes in one cycle, reads zero and discards any write.

Top module: `fb_bank`

## Requirements
- R1: Word 0x00 holds read/write field A (A_W=8 bits) at bits [7:0] and read/write field B (B_W=4 bits) at [11:8]. A write updates both fields from the matching write-data bits, and bits [31:12] read as zero.
- R2: Word 0x04 holds the status field at [7:0] and the read-only field at [23:8]. The read-only field returns ro_data_i, and bits [31:24] read as zero. A write to word 0x04 leaves the read-only field unaffected.
- R3: Each write-data bit of 1 in [7:0] of a write to 0x04 clears the matching status bit, and bits written as 0 keep their value. A status bit whose stat_set_i bit is high in the clock cycle of the clear stays 1. A read returns the status value from before any set that lands in the same cycle.
- R4: A read of 0x08 returns queue source 0 data in [15:0] and source 1 data in [31:16]. The response waits until both sources have had their handshake. Each src_ready_o bit is high only while its source is unserved, so there is exactly one transfer per source per read. A write to 0x08 completes, ignores its data and raises no src_ready_o.
- R5: A write to 0x0C raises q_valid_o with q_data_o equal to write data [15:0]. Both are held until q_ready_i is high, which gives exactly one transfer, and the response waits for that transfer. A read of 0x0C returns zero and raises no q_valid_o.
- R6: An access to any other address, and any access whose fields are all ready, raises rsp_valid_o at the first rising edge after the request is accepted. An unmapped access reads zero and changes no field.
- R7: req_ready_o is low from the acceptance edge until the response handshake. rsp_valid_o and rsp_rdata_o are held while rsp_ready_i is low.
- R8: After reset, req_ready_o is 1, rsp_valid_o, q_valid_o and src_ready_o are 0, and fields A, B and status are zero.
- R9: A value written to a read/write field is returned by the next read of that word, and it replaces the old value completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address, 4-aligned |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_rdata_o | output | 32 | Read data (zero for writes) |
| ro_data_i | input | RO_W | Value of the read-only field |
| stat_set_i | input | ST_W | Hardware set of status bits |
| src_valid_i | input | 2 | Queue sources have data |
| src_data_i | input | 2*Q_W | Queue source data, source 0 low |
| src_ready_o | output | 2 | Queue source pop |
| q_valid_o | output | 1 | Queue sink push valid |
| q_data_o | output | Q_W | Queue sink push data |
| q_ready_i | input | 1 | Queue sink can accept |

## Verification
A completion flag that is wrong in one field has two possible effects. Either an extra queue pop or push shows up at src_ready_o or q_valid_o in the cycle after the real transfer, or the response never arrives and the bench watchdog ends the run. A status bit cleared or set wrongly shows up at the next read of 0x04. A wrong read/write field value shows up at the next read of 0x00. A stall in the response path shows as a latency other than one cycle on an access whose fields are all ready, and the bench sees it on that same access.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} fb_state_e;
endpackage

// File: rtl/fb_slot.sv
// One field's handshake tracker within the current access.
module fb_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic ack_i,
  output logic valid_o,
  output logic fire_o,
  output logic done_o
);
  logic done_q;

  assign valid_o = sel_i & ~done_q;
  assign fire_o  = valid_o & ack_i;
  assign done_o  = ~sel_i | done_q | ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     done_q <= 1'b0;
    else if (!sel_i) done_q <= 1'b0;
    else if (fire_o) done_q <= 1'b1;
  end
endmodule

// File: rtl/fb_w1c.sv
// Status bits: bus write-one clears, hardware set wins.
module fb_w1c #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/fb_front.sv
// Bus front end: accept, hold request, gather read data, respond.
module fb_front
  import fb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              all_done_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  fb_state_e         state_q;
  logic [DATA_W-1:0] rdata_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign busy_o      = (state_q == ST_BUSY);
  assign rsp_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_BUSY;
          we_o    <= req_write_i;
          addr_o  <= req_addr_i;
          wdata_o <= req_wdata_i;
          rdata_q <= '0;
        end
        ST_BUSY: begin
          rdata_q <= rdata_q | rd_word_i;
          if (all_done_i) state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter int          ADDR_W   = 8,
  parameter int          A_W      = 8,
  parameter int          B_W      = 4,
  parameter int          ST_W     = 8,
  parameter int          RO_W     = 16,
  parameter int          Q_W      = 16,
  parameter logic [7:0]  CTRL_OFS = 8'h00,
  parameter logic [7:0]  STAT_OFS = 8'h04,
  parameter logic [7:0]  SRC_OFS  = 8'h08,
  parameter logic [7:0]  SINK_OFS = 8'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [31:0]       rsp_rdata_o,
  input  logic [RO_W-1:0]   ro_data_i,
  input  logic [ST_W-1:0]   stat_set_i,
  input  logic [1:0]        src_valid_i,
  input  logic [2*Q_W-1:0]  src_data_i,
  output logic [1:0]        src_ready_o,
  output logic              q_valid_o,
  output logic [Q_W-1:0]    q_data_o,
  input  logic              q_ready_i
);
  localparam int DATA_W = 32;
  localparam int NSLOT  = 7;
  // slot numbering
  localparam int SL_A = 0, SL_B = 1, SL_ST = 2, SL_RO = 3, SL_S0 = 4, SL_S1 = 5, SL_K = 6;
  // packing: first field of a word at bit 0, next fields above it
  localparam int A_LSB  = 0;
  localparam int B_LSB  = A_LSB + A_W;
  localparam int ST_LSB = 0;
  localparam int RO_LSB = ST_LSB + ST_W;
  localparam int S0_LSB = 0;
  localparam int S1_LSB = S0_LSB + Q_W;
  localparam int K_LSB  = 0;
  localparam logic [ADDR_W-1:0] SLOT_ADDR [NSLOT] = '{
    ADDR_W'(CTRL_OFS), ADDR_W'(CTRL_OFS), ADDR_W'(STAT_OFS), ADDR_W'(STAT_OFS),
    ADDR_W'(SRC_OFS),  ADDR_W'(SRC_OFS),  ADDR_W'(SINK_OFS)};

  logic              busy, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_word;
  logic [NSLOT-1:0]  sel, ack, vld, fire, done;
  logic [A_W-1:0]    a_q;
  logic [B_W-1:0]    b_q;
  logic [ST_W-1:0]   stat_q, stat_clr;

  fb_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_rdata_o (rsp_rdata_o),
    .all_done_i  (&done),
    .rd_word_i   (rd_word),
    .busy_o      (busy),
    .we_o        (we_q),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign sel[i] = busy & (addr_q == SLOT_ADDR[i]);
    fb_slot u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel[i]),
      .ack_i   (ack[i]),
      .valid_o (vld[i]),
      .fire_o  (fire[i]),
      .done_o  (done[i])
    );
  end

  // per-field ready / output-valid
  always_comb begin
    ack        = '1;
    ack[SL_S0] = we_q | src_valid_i[0];
    ack[SL_S1] = we_q | src_valid_i[1];
    ack[SL_K]  = ~we_q | q_ready_i;
  end

  assign src_ready_o[0] = vld[SL_S0] & ~we_q;
  assign src_ready_o[1] = vld[SL_S1] & ~we_q;
  assign q_valid_o      = vld[SL_K] & we_q;
  assign q_data_o       = wdata_q[K_LSB +: Q_W];

  // read data: only fields handshaking this cycle contribute
  always_comb begin
    rd_word = '0;
    if (!we_q) begin
      if (fire[SL_A])  rd_word[A_LSB  +: A_W]  = a_q;
      if (fire[SL_B])  rd_word[B_LSB  +: B_W]  = b_q;
      if (fire[SL_ST]) rd_word[ST_LSB +: ST_W] = stat_q;
      if (fire[SL_RO]) rd_word[RO_LSB +: RO_W] = ro_data_i;
      if (fire[SL_S0]) rd_word[S0_LSB +: Q_W]  = src_data_i[0 +: Q_W];
      if (fire[SL_S1]) rd_word[S1_LSB +: Q_W]  = src_data_i[Q_W +: Q_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (fire[SL_A] && we_q) a_q <= wdata_q[A_LSB +: A_W];
      if (fire[SL_B] && we_q) b_q <= wdata_q[B_LSB +: B_W];
    end
  end

  assign stat_clr = (fire[SL_ST] && we_q) ? wdata_q[ST_LSB +: ST_W] : '0;

  fb_w1c #(.W(ST_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stat_clr),
    .set_i  (stat_set_i),
    .q_o    (stat_q)
  );
endmodule

// File: rtl/fb_bank_chk.sv
module fb_bank_chk #(
  parameter int ST_W = 8,
  parameter int Q_W  = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [31:0]     rsp_rdata_o,
  input logic [1:0]      src_valid_i,
  input logic [1:0]      src_ready_o,
  input logic            q_valid_o,
  input logic            q_ready_i,
  input logic [Q_W-1:0]  q_data_o,
  input logic [ST_W-1:0] stat_set_i,
  input logic [ST_W-1:0] stat_q
);
  a_r7_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  a_r7_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o));
  a_r5_sink_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && !q_ready_i |=> q_valid_o && $stable(q_data_o));
  a_r4_src0_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o[0] && src_valid_i[0] |=> !src_ready_o[0]);
  a_r4_src1_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o[1] && src_valid_i[1] |=> !src_ready_o[1]);
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_set_i) |=> ((stat_q & $past(stat_set_i)) == $past(stat_set_i)));
endmodule

bind fb_bank fb_bank_chk #(.ST_W(ST_W), .Q_W(Q_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_rdata_o (rsp_rdata_o),
  .src_valid_i (src_valid_i),
  .src_ready_o (src_ready_o),
  .q_valid_o   (q_valid_o),
  .q_ready_i   (q_ready_i),
  .q_data_o    (q_data_o),
  .stat_set_i  (stat_set_i),
  .stat_q      (stat_q)
);

// File: tb/fb_bank_tb.sv
`timescale 1ns/1ps
module fb_bank_tb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 0, q_ready = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [15:0] ro_data = 0;
  logic [7:0]  stat_set = 0;
  logic [1:0]  src_valid = 0;
  logic [31:0] src_data = 0;
  logic        req_ready_o, rsp_valid_o, q_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [1:0]  src_ready_o;
  logic [15:0] q_data_o;

  int n_chk = 0, n_err = 0;
  int q_cnt = 0, s0_cnt = 0, s1_cnt = 0;
  logic [15:0] q_last = 0;
  bit done_flag = 0;

  // model state
  logic [7:0] a_m = 0;
  logic [3:0] b_m = 0;
  logic [7:0] st_m = 0;

  always #10 clk = ~clk;

  fb_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata_o),
    .ro_data_i(ro_data), .stat_set_i(stat_set),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready_o),
    .q_valid_o(q_valid_o), .q_data_o(q_data_o), .q_ready_i(q_ready));

  always @(posedge clk) begin
    if (q_valid_o && q_ready) begin q_cnt++; q_last = q_data_o; end
    if (src_ready_o[0] && src_valid[0]) s0_cnt++;
    if (src_ready_o[1] && src_valid[1]) s1_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic acc(input bit we, input logic [7:0] addr, input logic [31:0] wd,
                     input logic [7:0] setm, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = addr; req_wdata = wd;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid = 0; stat_set = setm; lat = 1;
    chk("R7 ready low while busy", {31'b0, req_ready_o}, 32'd0);
    while (!rsp_valid_o && lat < 60) begin
      @(negedge clk); stat_set = 0; lat++;
    end
    stat_set = 0;
    rd = rsp_rdata_o;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] addr);
    case (addr)
      8'h00: return {20'b0, b_m, a_m};
      8'h04: return {8'b0, ro_data, st_m};
      8'h08: return src_data;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat, c0, c1, qc;
    void'($urandom(32'h1357_9bdf));
    ro_data  = 16'hbeef;
    src_data = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 req_ready", {31'b0, req_ready_o}, 32'd1);
    chk("R8 rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
    chk("R8 q_valid",   {31'b0, q_valid_o}, 32'd0);
    chk("R8 src_ready", {30'b0, src_ready_o}, 32'd0);
    rst_ni = 1;
    acc(0, 8'h00, 0, 0, rd, lat);
    chk("R8 fields A/B zero", rd, 32'd0);
    acc(0, 8'h04, 0, 0, rd, lat);
    chk("R8 status zero, R2 layout", rd, {8'b0, 16'hbeef, 8'h00});

    // R1/R9 write and read back, reserved bits zero
    acc(1, 8'h00, 32'hffff_fa5c, 0, rd, lat);
    a_m = 8'h5c; b_m = 4'ha;
    chk("R1 write rsp data zero", rd, 32'd0);
    chk("R6 latency all-ready", lat, 2);
    acc(0, 8'h00, 0, 0, rd, lat);
    chk("R1 R9 packing", rd, 32'h0000_0a5c);
    acc(1, 8'h00, 32'h0000_0300, 0, rd, lat);
    a_m = 8'h00; b_m = 4'h3;
    acc(0, 8'h00, 0, 0, rd, lat);
    chk("R9 replace", rd, 32'h0000_0300);

    // R3 set, clear, set-wins
    acc(0, 8'h10, 0, 8'hf0, rd, lat);
    st_m = 8'hf0;
    chk("R6 unmapped read zero", rd, 32'd0);
    chk("R6 unmapped latency", lat, 2);
    acc(0, 8'h04, 0, 8'h01, rd, lat);
    chk("R3 read returns pre-set value", rd, {8'b0, 16'hbeef, 8'hf0});
    st_m = 8'hf1;
    acc(1, 8'h04, 32'hffff_ff30, 8'h20, rd, lat);
    st_m = 8'hc1 | 8'h20; // 0x10 cleared, 0x20 set wins
    acc(0, 8'h04, 0, 0, rd, lat);
    chk("R3 clear with set priority, R2 ro unaffected", rd, {8'b0, 16'hbeef, st_m});

    // R6 unmapped write changes nothing
    acc(1, 8'h3c, 32'hffff_ffff, 0, rd, lat);
    acc(0, 8'h00, 0, 0, rd, lat);
    chk("R6 unmapped write dropped", rd, exp_rd(8'h00));

    // R4 stalled sources
    src_valid = 2'b00; c0 = s0_cnt; c1 = s1_cnt;
    fork
      acc(0, 8'h08, 0, 0, rd, lat);
      begin
        repeat (2) @(negedge clk); src_valid = 2'b01;
        repeat (4) @(negedge clk); src_valid = 2'b11;
      end
    join
    chk("R4 data both sources", rd, 32'h1234_5678);
    chk("R4 src0 one transfer", s0_cnt - c0, 1);
    chk("R4 src1 one transfer", s1_cnt - c1, 1);
    chk("R4 response waited", {31'b0, lat > 4}, 32'd1);
    c0 = s0_cnt;
    acc(1, 8'h08, 32'hdead_beef, 0, rd, lat);
    chk("R4 write to sources no pop", s0_cnt - c0, 0);
    chk("R4 write latency", lat, 2);

    // R5 stalled sink
    q_ready = 0; qc = q_cnt;
    fork
      acc(1, 8'h0c, 32'hcafe_a55a, 0, rd, lat);
      begin repeat (5) @(negedge clk); q_ready = 1; end
    join
    chk("R5 one push", q_cnt - qc, 1);
    chk("R5 push data", {16'b0, q_last}, 32'h0000_a55a);
    chk("R5 response waited", {31'b0, lat > 3}, 32'd1);
    qc = q_cnt;
    acc(0, 8'h0c, 0, 0, rd, lat);
    chk("R5 read sink zero", rd, 32'd0);
    chk("R5 read no push", q_cnt - qc, 0);

    // random mix
    src_valid = 2'b11; q_ready = 1;
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  ad, sm;
      logic [31:0] wd, ex;
      bit          we;
      int          qb;
      case ($urandom_range(5, 0))
        0: ad = 8'h00; 1: ad = 8'h04; 2: ad = 8'h08;
        3: ad = 8'h0c; 4: ad = 8'h10; default: ad = 8'h3c;
      endcase
      we = $urandom_range(1, 0);
      wd = $urandom;
      sm = ($urandom_range(3, 0) == 0) ? 8'($urandom) : 8'h00;
      ro_data = 16'($urandom);
      ex = exp_rd(ad);
      qb = q_cnt;
      acc(we, ad, wd, sm, rd, lat);
      if (we) begin
        if (ad == 8'h00) begin a_m = wd[7:0]; b_m = wd[11:8]; end
        if (ad == 8'h04) st_m = st_m & ~wd[7:0];
        chk("R6 R7 write rsp zero", rd, 32'd0);
        if (ad == 8'h0c) begin
          chk("R5 random push count", q_cnt - qb, 1);
          chk("R5 random push data", {16'b0, q_last}, {16'b0, wd[15:0]});
        end
      end else begin
        chk("R1 R2 R3 R4 random read", rd, ex);
      end
      st_m = st_m | sm;
      chk("R6 random latency", lat, 2);
    end
    finish_run();
  end
endmodule